// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block gathers a parameterised number of interrupt lines, grouped in sets of 32. It holds the per-line enable, pending, priority, CPU-target and trigger-mode state, and exposes that state through a 32-bit word-addressed register port. Peripheral inputs are latched into the pending state, either while they are high or on a rising edge, and only while the line is enabled and distribution is switched on globally. The block then picks the highest-priority pending, enabled line and offers it to a CPU-interface block. That block acknowledges the line by its ID.

Each per-line state has two write views. A 1 in the set view sets the bit and a 1 in the clear view clears it. Software raises one of the 16 software-generated lines by writing its ID to a dedicated word. Priority and target bytes honour per-byte write enables, so one line's byte can be changed without touching its neighbours. Lines 0–15 are software-generated, 16–31 are private per-CPU lines, and 32 and up are shared. Only shared lines have a writable trigger mode.

Top module: `idist_top`

## Requirements
- R1: After reset the control bit, all enables, pending bits, priorities, targets and trigger fields are 0, and best_valid is 0.
- R2: The word at byte offset 0x004 reads NUM_GROUPS-1 in bits [4:0] and 0 above, so the line count is 32*(value+1).
- R3: At 0x100+4w and 0x180+4w, where w = id>>5 and the bit is id&31, a 1 bit enables (set view) or disables (clear view) the line. 0 bits leave the line as it is. Both views read back the current enable bits.
- R4: At 0x200+4w and 0x280+4w, with the same indexing as R3, a 1 bit sets or clears the line's pending state. Both views read back the current pending bits.
- R5: The priority byte of a line sits at 0x400+4*(id>>2), byte lane id&3. Only lanes whose reg_be bit is 1 are written.
- R6: The 8-bit CPU target mask of a line sits at byte address 0x800+id (word 0x800+4*(id>>2), lane id&3). A single-lane write changes that byte only.
- R7: Trigger fields are 2 bits per line at bit 2*(id%16) of word 0xC00+4*(id>>4). Field bit 1 = 1 selects edge and 0 selects level. Writes to the words for IDs below 32 are ignored, and those words read 0.
- R8: A level line that is enabled, with distribution on and its input high, is set pending on every clock. An acknowledge or a pending-clear while the input is high leaves it pending. After the input falls, it stays pending until it is acknowledged or cleared.
- R9: An edge line is set pending only on a 0-to-1 input transition. It stays pending after the input falls, until it is acknowledged or cleared. Holding the input high after an acknowledge does not set it pending again.
- R10: Hardware inputs do not set pending on a line that is disabled, or while control bit 0 is 0. While control bit 0 is 0, best_valid is 0 whatever is pending.
- R11: best_id names the pending, enabled line with the numerically lowest priority byte, and ties go to the lowest ID. best_prio and best_targets carry that line's priority and target bytes.
- R12: Enable, pending, priority, target and trigger words beyond the configured line count read 0, and writes to them change nothing. The group region (0x080–0x0FC) reads 0.
- R13: A write to 0xF00 sets pending on the software-generated line whose ID is in reg_wdata[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_word_addr | input | 10 | Word address (byte offset >> 2) |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte-lane write enables (priority and target regions) |
| reg_rdata | output | 32 | Read data for reg_word_addr, combinational |
| irq_in | input | 32*NUM_GROUPS | Interrupt input lines |
| ack_valid | input | 1 | Acknowledge from the CPU interface |
| ack_id | input | $clog2(32*NUM_GROUPS) | ID being acknowledged |
| best_valid | output | 1 | A line is offered |
| best_id | output | $clog2(32*NUM_GROUPS) | Offered line |
| best_prio | output | 8 | Priority of the offered line |
| best_targets | output | 8 | CPU target mask of the offered line |

## Verification
The bench probes these corner cases:
- A set-view write made of 0 bits. A design that treated it as a plain store would wipe enables.
- A partial-lane priority or target write. A design that ignored reg_be would overwrite neighbouring lines.
- Trigger writes to the private and software-generated words. A design that failed to block them would let those lines be reconfigured.
- An acknowledge while a level input is still high, which must leave the line pending.
- An edge input held high after an acknowledge, which must not re-trigger.
- An arbitration tie, where a design that scanned in the wrong direction or used a non-strict compare would offer the higher ID.
- Out-of-range words, and switching distribution off while lines are pending.

// File: rtl/idist_pkg.sv
package idist_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_GROUP, RG_EN_SET, RG_EN_CLR,
    RG_PD_SET, RG_PD_CLR, RG_PRIO, RG_TGT, RG_CFG, RG_SWI
  } region_e;

  // Word-address decode of the distributor map.
  function automatic region_e decode_region(input logic [9:0] wa);
    region_e r;
    r = RG_NONE;
    if (wa == 10'h000)             r = RG_CTRL;
    else if (wa == 10'h001)        r = RG_TYPE;
    else if (wa[9:5] == 5'd1)      r = RG_GROUP;
    else if (wa[9:5] == 5'd2)      r = RG_EN_SET;
    else if (wa[9:5] == 5'd3)      r = RG_EN_CLR;
    else if (wa[9:5] == 5'd4)      r = RG_PD_SET;
    else if (wa[9:5] == 5'd5)      r = RG_PD_CLR;
    else if (wa[9:8] == 2'b01)     r = RG_PRIO;
    else if (wa[9:8] == 2'b10)     r = RG_TGT;
    else if (wa[9:6] == 4'hC)      r = RG_CFG;
    else if (wa == 10'h3C0)        r = RG_SWI;
    return r;
  endfunction

endpackage

// File: rtl/idist_cfg_bank.sv
module idist_cfg_bank
  import idist_pkg::*;
#(
  parameter int NUM_GROUPS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  region_e                 region,
  input  logic [7:0]              word_idx,
  input  logic [31:0]             wdata,
  input  logic [3:0]              be,
  output logic [32*NUM_GROUPS*8-1:0] prio_flat,
  output logic [32*NUM_GROUPS*8-1:0] tgt_flat,
  output logic [32*NUM_GROUPS-1:0]   edge_sel,
  output logic [31:0]             rdata
);
  localparam int NL      = 32 * NUM_GROUPS;
  localparam int BYTE_WD = NL / 4;   // priority / target words
  localparam int CFG_WD  = NL / 16;  // trigger words
  localparam int CFG_LO  = 2;        // first writable trigger word (ID 32)

  logic [NL*8-1:0] prio_q, prio_d, tgt_q, tgt_d;
  logic [NL*2-1:0] cfg_q, cfg_d;
  logic            prio_we, tgt_we, cfg_we;
  int              bidx, cidx;

  always_comb begin
    bidx    = int'(word_idx);
    cidx    = int'(word_idx[5:0]);
    prio_we = wr_en && (region == RG_PRIO) && (bidx < BYTE_WD);
    tgt_we  = wr_en && (region == RG_TGT)  && (bidx < BYTE_WD);
    cfg_we  = wr_en && (region == RG_CFG)  && (cidx < CFG_WD) && (cidx >= CFG_LO);
    prio_d  = prio_q;
    tgt_d   = tgt_q;
    cfg_d   = cfg_q;
    for (int b = 0; b < 4; b++) begin
      if (prio_we && be[b]) prio_d[bidx*32 + b*8 +: 8] = wdata[b*8 +: 8];
      if (tgt_we  && be[b]) tgt_d[bidx*32 + b*8 +: 8]  = wdata[b*8 +: 8];
    end
    if (cfg_we) cfg_d[cidx*32 +: 32] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      tgt_q  <= '0;
      cfg_q  <= '0;
    end else begin
      if (prio_we) prio_q <= prio_d;
      if (tgt_we)  tgt_q  <= tgt_d;
      if (cfg_we)  cfg_q  <= cfg_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (region)
      RG_PRIO: if (bidx < BYTE_WD) rdata = prio_q[bidx*32 +: 32];
      RG_TGT:  if (bidx < BYTE_WD) rdata = tgt_q[bidx*32 +: 32];
      RG_CFG:  if (cidx < CFG_WD)  rdata = cfg_q[cidx*32 +: 32];
      default: rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NL; i++) begin : g_edge
    assign edge_sel[i] = cfg_q[2*i + 1];
  end

  assign prio_flat = prio_q;
  assign tgt_flat  = tgt_q;

  AST_LOW_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (region == RG_CFG) && (word_idx[5:0] < 6'(CFG_LO)) |=> $stable(cfg_q[CFG_LO*32-1:0])); // R7
endmodule

// File: rtl/idist_pend.sv
module idist_pend #(
  parameter int NL   = 64,
  parameter int ID_W = $clog2(NL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dist_en,
  input  logic [NL-1:0]   en,
  input  logic [NL-1:0]   edge_sel,
  input  logic [NL-1:0]   irq_in,
  input  logic [NL-1:0]   sw_set,
  input  logic [NL-1:0]   sw_clr,
  input  logic            ack_valid,
  input  logic [ID_W-1:0] ack_id,
  output logic [NL-1:0]   pend_q
);
  logic [NL-1:0] irq_prev, hw_set, clr_v, pend_d;

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic rise;
    assign rise      = irq_in[i] & ~irq_prev[i];
    assign hw_set[i] = dist_en & en[i] & (edge_sel[i] ? rise : irq_in[i]);
    assign clr_v[i]  = sw_clr[i] | (ack_valid && (ack_id == ID_W'(i)));
    assign pend_d[i] = (pend_q[i] & ~clr_v[i]) | hw_set[i] | sw_set[i];

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dist_en && en[i] && !edge_sel[i] && irq_in[i] |=> pend_q[i]); // R8
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[i] && !(dist_en && en[i]) && !sw_set[i] |=> !pend_q[i]); // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      irq_prev <= '0;
    end else begin
      pend_q   <= pend_d;
      irq_prev <= irq_in;
    end
  end
endmodule

// File: rtl/idist_arb.sv
module idist_arb #(
  parameter int NL   = 64,
  parameter int ID_W = $clog2(NL)
) (
  input  logic [NL-1:0]   cand,
  input  logic [NL*8-1:0] prio_flat,
  input  logic [NL*8-1:0] tgt_flat,
  output logic            best_valid,
  output logic [ID_W-1:0] best_id,
  output logic [7:0]      best_prio,
  output logic [7:0]      best_tgt
);
  always_comb begin
    best_valid = 1'b0;
    best_id    = '0;
    best_prio  = 8'hFF;
    // Strict compare in ascending ID order: ties keep the lower ID.
    for (int i = 0; i < NL; i++) begin
      if (cand[i] && (!best_valid || (prio_flat[i*8 +: 8] < best_prio))) begin
        best_valid = 1'b1;
        best_id    = ID_W'(i);
        best_prio  = prio_flat[i*8 +: 8];
      end
    end
    if (!best_valid) best_prio = '0;
    best_tgt = best_valid ? tgt_flat[int'(best_id)*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/idist_top.sv
module idist_top
  import idist_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  localparam int NL   = 32 * NUM_GROUPS,
  localparam int ID_W = $clog2(NL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_en,
  input  logic [9:0]      reg_word_addr,
  input  logic [31:0]     reg_wdata,
  input  logic [3:0]      reg_be,
  output logic [31:0]     reg_rdata,
  input  logic [NL-1:0]   irq_in,
  input  logic            ack_valid,
  input  logic [ID_W-1:0] ack_id,
  output logic            best_valid,
  output logic [ID_W-1:0] best_id,
  output logic [7:0]      best_prio,
  output logic [7:0]      best_targets
);
  region_e         region;
  logic            ctrl_q, ctrl_we;
  logic [NL-1:0]   en_q, en_d, pend_q, sw_set, sw_clr, edge_sel, cand;
  logic            en_we, grp_ok;
  logic [NL*8-1:0] prio_flat, tgt_flat;
  logic [31:0]     bank_rdata;
  int              gidx;

  always_comb begin
    region  = decode_region(reg_word_addr);
    gidx    = int'(reg_word_addr[4:0]);
    grp_ok  = gidx < NUM_GROUPS;
    ctrl_we = reg_wr_en && (region == RG_CTRL);
    en_we   = reg_wr_en && grp_ok && ((region == RG_EN_SET) || (region == RG_EN_CLR));
    en_d    = en_q;
    if (en_we) begin
      if (region == RG_EN_SET) en_d[gidx*32 +: 32] = en_q[gidx*32 +: 32] | reg_wdata;
      else                     en_d[gidx*32 +: 32] = en_q[gidx*32 +: 32] & ~reg_wdata;
    end
    sw_set = '0;
    sw_clr = '0;
    if (reg_wr_en && grp_ok && (region == RG_PD_SET)) sw_set[gidx*32 +: 32] = reg_wdata;
    if (reg_wr_en && grp_ok && (region == RG_PD_CLR)) sw_clr[gidx*32 +: 32] = reg_wdata;
    if (reg_wr_en && (region == RG_SWI))
      sw_set[{{(ID_W-4){1'b0}}, reg_wdata[3:0]}] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      en_q   <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= reg_wdata[0];
      if (en_we)   en_q   <= en_d;
    end
  end

  idist_cfg_bank #(.NUM_GROUPS(NUM_GROUPS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .region(region),
    .word_idx(reg_word_addr[7:0]), .wdata(reg_wdata), .be(reg_be),
    .prio_flat(prio_flat), .tgt_flat(tgt_flat), .edge_sel(edge_sel),
    .rdata(bank_rdata)
  );

  idist_pend #(.NL(NL), .ID_W(ID_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .dist_en(ctrl_q), .en(en_q), .edge_sel(edge_sel),
    .irq_in(irq_in), .sw_set(sw_set), .sw_clr(sw_clr),
    .ack_valid(ack_valid), .ack_id(ack_id), .pend_q(pend_q)
  );

  assign cand = pend_q & en_q & {NL{ctrl_q}};

  idist_arb #(.NL(NL), .ID_W(ID_W)) u_arb (
    .cand(cand), .prio_flat(prio_flat), .tgt_flat(tgt_flat),
    .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio),
    .best_tgt(best_targets)
  );

  always_comb begin
    reg_rdata = '0;
    case (region)
      RG_CTRL:              reg_rdata = {31'b0, ctrl_q};
      RG_TYPE:              reg_rdata = 32'(NUM_GROUPS - 1);
      RG_EN_SET, RG_EN_CLR: if (grp_ok) reg_rdata = en_q[gidx*32 +: 32];
      RG_PD_SET, RG_PD_CLR: if (grp_ok) reg_rdata = pend_q[gidx*32 +: 32];
      RG_PRIO, RG_TGT, RG_CFG: reg_rdata = bank_rdata;
      default:              reg_rdata = '0;
    endcase
  end

  AST_OFF_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q |-> !best_valid); // R10
  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> (pend_q[best_id] && en_q[best_id])); // R11
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && (reg_word_addr == 10'h040) && reg_wdata[0] |=> en_q[0]); // R3
endmodule

// File: tb/tb_idist_top.sv
`timescale 1ns/1ps
module tb_idist_top;
  localparam int NG = 2;
  localparam int NL = 32 * NG;
  localparam int IW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_en;
  logic [9:0]    reg_word_addr;
  logic [31:0]   reg_wdata;
  logic [3:0]    reg_be;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] irq_in;
  logic          ack_valid;
  logic [IW-1:0] ack_id;
  logic          best_valid;
  logic [IW-1:0] best_id;
  logic [7:0]    best_prio, best_targets;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  idist_top #(.NUM_GROUPS(NG)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_word_addr(reg_word_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_id(ack_id), .best_valid(best_valid), .best_id(best_id),
    .best_prio(best_prio), .best_targets(best_targets)
  );

  // {req[84:81], read[80], addr[79:68], data[67:36], be[35:32], expect[31:0]}
  localparam int NV = 33;
  localparam logic [84:0] VEC [0:NV-1] = '{
    {4'd3,  1'b0, 12'h100, 32'h0000_0005, 4'hF, 32'h0},          // R3 enable 0,2
    {4'd3,  1'b1, 12'h100, 32'h0,         4'h0, 32'h0000_0005},
    {4'd3,  1'b1, 12'h180, 32'h0,         4'h0, 32'h0000_0005},
    {4'd3,  1'b0, 12'h104, 32'h8000_0001, 4'hF, 32'h0},          // R3 ids 32,63
    {4'd3,  1'b0, 12'h180, 32'h0000_0004, 4'hF, 32'h0},          // R3 disable id2
    {4'd3,  1'b1, 12'h100, 32'h0,         4'h0, 32'h0000_0001},
    {4'd3,  1'b1, 12'h184, 32'h0,         4'h0, 32'h8000_0001},
    {4'd3,  1'b0, 12'h100, 32'h0,         4'hF, 32'h0},          // R3 zero bits
    {4'd3,  1'b1, 12'h100, 32'h0,         4'h0, 32'h0000_0001},
    {4'd2,  1'b1, 12'h004, 32'h0,         4'h0, 32'h0000_0001},  // R2
    {4'd5,  1'b0, 12'h400, 32'h4433_2211, 4'h5, 32'h0},          // R5 lanes 0,2
    {4'd5,  1'b1, 12'h400, 32'h0,         4'h0, 32'h0033_0011},
    {4'd6,  1'b0, 12'h808, 32'h0000_AB00, 4'h2, 32'h0},          // R6 id9
    {4'd6,  1'b1, 12'h808, 32'h0,         4'h0, 32'h0000_AB00},
    {4'd6,  1'b0, 12'h808, 32'h00CD_0000, 4'h4, 32'h0},          // R6 id10
    {4'd6,  1'b1, 12'h808, 32'h0,         4'h0, 32'h00CD_AB00},
    {4'd7,  1'b0, 12'hC00, 32'hFFFF_FFFF, 4'hF, 32'h0},          // R7 low ids
    {4'd7,  1'b1, 12'hC00, 32'h0,         4'h0, 32'h0},
    {4'd7,  1'b0, 12'hC08, 32'h0000_0008, 4'hF, 32'h0},          // R7 id33 edge
    {4'd7,  1'b1, 12'hC08, 32'h0,         4'h0, 32'h0000_0008},
    {4'd12, 1'b0, 12'h108, 32'hFFFF_FFFF, 4'hF, 32'h0},          // R12
    {4'd12, 1'b1, 12'h108, 32'h0,         4'h0, 32'h0},
    {4'd12, 1'b1, 12'h100, 32'h0,         4'h0, 32'h0000_0001},
    {4'd12, 1'b1, 12'h080, 32'h0,         4'h0, 32'h0},
    {4'd12, 1'b1, 12'h440, 32'h0,         4'h0, 32'h0},
    {4'd4,  1'b0, 12'h204, 32'h0000_0010, 4'hF, 32'h0},          // R4 id36
    {4'd4,  1'b1, 12'h204, 32'h0,         4'h0, 32'h0000_0010},
    {4'd4,  1'b0, 12'h284, 32'h0000_0010, 4'hF, 32'h0},
    {4'd4,  1'b1, 12'h204, 32'h0,         4'h0, 32'h0},
    {4'd13, 1'b0, 12'hF00, 32'h0000_0003, 4'hF, 32'h0},          // R13 id3
    {4'd13, 1'b1, 12'h200, 32'h0,         4'h0, 32'h0000_0008},
    {4'd13, 1'b0, 12'h280, 32'h0000_0008, 4'hF, 32'h0},
    {4'd13, 1'b1, 12'h200, 32'h0,         4'h0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_word_addr = a[11:2]; reg_wdata = d; reg_be = be;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_word_addr = a[11:2];
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic ack(input int id);
    @(negedge clk);
    ack_valid = 1'b1; ack_id = IW'(id);
    @(posedge clk); #1;
    ack_valid = 1'b0;
  endtask

  task automatic set_irq(input int id, input logic v);
    @(negedge clk);
    irq_in[id] = v;
  endtask

  task automatic offer(input string req, input logic v, input int id, input logic [7:0] p);
    @(negedge clk); #1;
    chk({req, " valid"}, 32'(best_valid), 32'(v));
    if (v) begin
      chk({req, " id"}, 32'(best_id), 32'(id));
      chk({req, " prio"}, 32'(best_prio), 32'(p));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_word_addr = '0; reg_wdata = '0; reg_be = '0;
    irq_in = '0; ack_valid = 1'b0; ack_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd("R1 ctrl", 12'h000, 32'h0);
    rd("R1 enable", 12'h104, 32'h0);
    rd("R1 pending", 12'h200, 32'h0);
    rd("R1 prio", 12'h41C, 32'h0);
    rd("R1 cfg", 12'hC0C, 32'h0);
    offer("R1 offer", 1'b0, 0, 8'h00);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][80])
        rd($sformatf("R%0d vec%0d", VEC[k][84:81], k), VEC[k][79:68], VEC[k][31:0]);
      else
        wr(VEC[k][79:68], VEC[k][67:36], VEC[k][35:32]);
    end

    // R10: distribution off, enabled level line 32 high: no latch
    set_irq(32, 1'b1);
    rd("R10 off no latch", 12'h204, 32'h0);
    irq_in[32] = 1'b0;
    // R10: disabled line 34 high with distribution on: no latch
    wr(12'h000, 32'h1, 4'hF);
    rd("R10 ctrl on", 12'h000, 32'h1);
    set_irq(34, 1'b1);
    rd("R10 disabled line", 12'h204, 32'h0);
    set_irq(34, 1'b0);

    // R8 level trigger
    set_irq(32, 1'b1);
    rd("R8 level set", 12'h204, 32'h0000_0001);
    offer("R8 offer", 1'b1, 32, 8'h00);
    ack(32);
    rd("R8 ack while high", 12'h204, 32'h0000_0001);
    wr(12'h284, 32'h1, 4'hF);
    rd("R8 clear while high", 12'h204, 32'h0000_0001);
    set_irq(32, 1'b0);
    rd("R8 held after fall", 12'h204, 32'h0000_0001);
    ack(32);
    rd("R8 ack after fall", 12'h204, 32'h0);

    // R9 edge trigger on id33
    wr(12'h104, 32'h0000_0002, 4'hF);
    set_irq(33, 1'b1);
    rd("R9 edge set", 12'h204, 32'h0000_0002);
    set_irq(33, 1'b0);
    rd("R9 held after fall", 12'h204, 32'h0000_0002);
    ack(33);
    rd("R9 ack", 12'h204, 32'h0);
    set_irq(33, 1'b1);
    ack(33);
    rd("R9 no retrigger", 12'h204, 32'h0);
    set_irq(33, 1'b0);

    // R11 arbitration
    wr(12'h420, 32'h0000_0080, 4'h1);       // id32 prio 0x80
    wr(12'h43C, 32'h4000_0000, 4'h8);       // id63 prio 0x40
    wr(12'h83C, 32'h5A00_0000, 4'h8);       // id63 targets 0x5A
    wr(12'h204, 32'h8000_0001, 4'hF);       // pend 32,63
    offer("R11 lowest value", 1'b1, 63, 8'h40);
    chk("R11 targets", 32'(best_targets), 32'h5A);
    wr(12'h200, 32'h0000_0001, 4'hF);       // pend id0 prio 0x11
    offer("R11 id0 wins", 1'b1, 0, 8'h11);
    wr(12'h43C, 32'h1100_0000, 4'h8);       // id63 prio 0x11: tie
    offer("R11 tie low id", 1'b1, 0, 8'h11);
    wr(12'h280, 32'h0000_0001, 4'hF);
    offer("R11 after clear", 1'b1, 63, 8'h11);

    // R10: switching distribution off hides pending lines
    wr(12'h000, 32'h0, 4'hF);
    offer("R10 off offer", 1'b0, 0, 8'h00);
    rd("R10 pending kept", 12'h204, 32'h8000_0001);

    // R1: mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd("R1 re-reset enable", 12'h100, 32'h0);
    rd("R1 re-reset pend", 12'h204, 32'h0);
    rd("R1 re-reset tgt", 12'h83C, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule